// File: doc/BRIEF.md
# Prescaled Schedule Timer with Alarm

The block is a free-running event timer for a control processor. A programmable power-of-two prescaler derives a count enable from the system clock. A counter advances on that enable. An alarm comparator watches each update of the counter and, when the count moves onto the programmed alarm value, sets a sticky alarm flag that can drive an interrupt line. Software reaches three 16-bit registers through a simple write-strobe and combinational-read bus: the control word, the counter and the alarm value.

An external synchronisation input lets a hardware event realign the schedule. Software arms it with a one-shot arm bit. The next rising edge on the input, after two synchroniser flops, restarts both the counter and the prescaler from zero and clears the arm bit. Edges that arrive while the arm bit is clear have no effect.

Top module: `sched_timer`

## Requirements
- R1: Register map by `reg_addr`: 0 = control word, 1 = counter, 2 = alarm value, 3 = reads zero. Every register is zero after reset and `irq` is low. Control word bit positions: 11:9 prescaler select N, 8 sync arm, 7 interrupt enable, 6 alarm flag, 1 alarm enable, 0 timer enable.
- R2: Control word bits 15:12 and 5:2 always read 0, and writing ones to them has no effect.
- R3: While the timer is enabled, the counter advances by one every 2^N system clocks (N = 0..7). Counting starts with a fresh prescaler phase on the first clock after the enable is written, so a run of K enabled clocks adds floor(K / 2^N).
- R4: The counter is 16 bits wide and wraps from 0xFFFF to 0x0000.
- R5: With the timer enable clear, the counter holds its value and the prescaler is held at phase zero.
- R6: The alarm flag is set on the clock where the counter, with timer enable and alarm enable both 1, moves onto a value equal to the alarm register.
- R7: With the alarm enable clear, passing the alarm value does not set the flag.
- R8: Writing 0 to control bit 6 clears the flag, and writing 1 leaves it unchanged. A counter parked at the alarm value does not set the flag again.
- R9: A match on the same clock as a clearing write wins, and the flag stays set.
- R10: `irq` is high exactly while the interrupt enable and the alarm flag are both 1.
- R11: While armed, a rising edge on `sync_in` sets the counter to 0 within three clocks and clears the arm bit. A later edge has no effect until software arms it again.
- R12: With the arm bit clear, edges on `sync_in` leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| sync_in | input | 1 | Asynchronous external synchronisation event |
| irq | output | 1 | Alarm interrupt request, active high |

## Verification
The bench builds the block with its default 16-bit counter and two-stage synchroniser. This makes the full 0xFFFF-to-0 wrap and every prescaler ratio from 1 to 128 reachable within short runs. Random runs cover prescaler selects, start counts and run lengths. Directed cases place the counter a few steps below the alarm, so that the match, the clear-versus-match collision and the parked-count case fall on exact, predictable clocks.

// File: rtl/st_pkg.sv
package st_pkg;

  localparam int REG_W = 16;
  localparam int DIV_W = 3;

  // control word field positions (software-visible layout)
  localparam int B_TEN   = 0;
  localparam int B_AEN   = 1;
  localparam int B_FLAG  = 6;
  localparam int B_IE    = 7;
  localparam int B_SYNC  = 8;
  localparam int B_DIV   = 9;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_ALARM = 2'd2,
    A_NONE  = 2'd3
  } st_addr_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             sync_en;
    logic             ie;
    logic             flag;
    logic             aen;
    logic             ten;
  } st_ctrl_t;

  function automatic logic [REG_W-1:0] pack_ctrl(st_ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_DIV +: DIV_W] = c.div;
    w[B_SYNC]         = c.sync_en;
    w[B_IE]           = c.ie;
    w[B_FLAG]         = c.flag;
    w[B_AEN]          = c.aen;
    w[B_TEN]          = c.ten;
    return w;
  endfunction

  function automatic st_ctrl_t unpack_ctrl(logic [REG_W-1:0] w);
    st_ctrl_t c;
    c.div     = w[B_DIV +: DIV_W];
    c.sync_en = w[B_SYNC];
    c.ie      = w[B_IE];
    c.flag    = w[B_FLAG];
    c.aen     = w[B_AEN];
    c.ten     = w[B_TEN];
    return c;
  endfunction

endpackage

// File: rtl/st_sync_edge.sv
module st_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/st_prescaler.sv
module st_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int PW = (1 << DIV_W) - 1;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] acc;
  logic [PW-1:0] mask;

  // mask = 2^sel - 1; the top select wraps to all ones
  assign mask = (ONE << sel) - ONE;
  assign tick = run && !restart && ((acc & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)                      acc <= '0;
    else if (!run || restart || tick) acc <= '0;
    else                             acc <= acc + ONE;
  end
endmodule

// File: rtl/st_counter.sv
module st_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             moved
);
  always_comb begin
    cnt_nxt = cnt;
    moved   = 1'b0;
    if (clear) begin
      cnt_nxt = '0;
      moved   = 1'b1;
    end else if (load) begin
      cnt_nxt = load_val;
      moved   = 1'b1;
    end else if (step) begin
      cnt_nxt = cnt + CNT_W'(1);
      moved   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/sched_timer.sv
module sched_timer
  import st_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sync_in,
  output logic             irq
);
  st_ctrl_t         ctrl_q;
  st_ctrl_t         ctrl_wr;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_moved;

  // named internal events
  logic ctrl_we, cnt_we, alm_we;
  logic sync_rise, sync_acc, tick, alarm_hit;
  logic st_ten, st_aen, st_flag, st_ie, st_sync_en;

  assign ctrl_we = reg_we && (st_addr_e'(reg_addr) == A_CTRL);
  assign cnt_we  = reg_we && (st_addr_e'(reg_addr) == A_COUNT);
  assign alm_we  = reg_we && (st_addr_e'(reg_addr) == A_ALARM);
  assign ctrl_wr = unpack_ctrl(reg_wdata);

  st_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sync_in), .rise(sync_rise)
  );

  assign sync_acc = sync_rise && ctrl_q.sync_en;

  st_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.ten), .restart(sync_acc),
    .sel(ctrl_q.div), .tick(tick)
  );

  st_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(sync_acc), .load(cnt_we),
    .load_val(reg_wdata[CNT_W-1:0]), .step(tick),
    .cnt(cnt_q), .cnt_nxt(cnt_nxt), .moved(cnt_moved)
  );

  // a match counts only when the counter moves onto the alarm value
  assign alarm_hit = ctrl_q.ten && ctrl_q.aen && cnt_moved && (cnt_nxt == alarm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      alarm_q <= '0;
    end else begin
      if (ctrl_we) begin
        ctrl_q.div  <= ctrl_wr.div;
        ctrl_q.ie   <= ctrl_wr.ie;
        ctrl_q.aen  <= ctrl_wr.aen;
        ctrl_q.ten  <= ctrl_wr.ten;
      end
      if (sync_acc)     ctrl_q.sync_en <= 1'b0;
      else if (ctrl_we) ctrl_q.sync_en <= ctrl_wr.sync_en;
      if (alarm_hit)                     ctrl_q.flag <= 1'b1;
      else if (ctrl_we && !ctrl_wr.flag) ctrl_q.flag <= 1'b0;
      if (alm_we) alarm_q <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (st_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = pack_ctrl(ctrl_q);
      A_COUNT: reg_rdata = REG_W'(cnt_q);
      A_ALARM: reg_rdata = REG_W'(alarm_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = ctrl_q.ie && ctrl_q.flag;

  assign st_ten     = ctrl_q.ten;
  assign st_aen     = ctrl_q.aen;
  assign st_flag    = ctrl_q.flag;
  assign st_ie      = ctrl_q.ie;
  assign st_sync_en = ctrl_q.sync_en;
endmodule

// File: rtl/st_checker.sv
module st_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ten,
  input logic             aen,
  input logic             flag,
  input logic             ie,
  input logic             sync_en,
  input logic             ctrl_we,
  input logic             cnt_we,
  input logic             sync_acc,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       reg_addr,
  input logic [15:0]      reg_rdata,
  input logic             irq
);
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ten); // R5
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ten && !sync_acc && !cnt_we) |=> $stable(cnt)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync_acc && !cnt_we) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R4
  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(ten) && $past(aen))); // R6
  AST_SYNC_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_acc && !ctrl_we) |=> !sync_en); // R11
  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sync_acc |=> (cnt == '0)); // R11
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> ((reg_rdata & 16'hF03C) == 16'h0000)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie)); // R10
endmodule

bind sched_timer st_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ten(st_ten), .aen(st_aen), .flag(st_flag),
  .ie(st_ie), .sync_en(st_sync_en), .ctrl_we(ctrl_we), .cnt_we(cnt_we),
  .sync_acc(sync_acc), .tick(tick), .cnt(cnt_q), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/sched_timer_test.sv
module sched_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd3;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sync_in = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_in(sync_in), .irq(irq)
  );

  // bench restatement of the control layout
  function automatic logic [15:0] cw(int div, bit sy, bit ie, bit fl, bit ae, bit te);
    return 16'((div & 7) * 512 + sy * 256 + ie * 128 + fl * 64 + ae * 2 + te);
  endfunction

  function automatic logic [15:0] exp_count(logic [15:0] start, int n, int run_clks);
    return 16'((32'(start) + (run_clks >> n)) % 65536);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5EED));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl reset", v, 16'h0000);
    rd(2'd1, v); check("R1 count reset", v, 16'h0000);
    rd(2'd2, v); check("R1 alarm reset", v, 16'h0000);
    rd(2'd3, v); check("R1 unused addr", v, 16'h0000);
    check("R1 irq reset", 16'(irq), 16'h0000);

    // R2 reserved bits, R8 writing 1 to flag does nothing
    wr(2'd0, 16'hF03C); rd(2'd0, v); check("R2 reserved only", v, 16'h0000);
    wr(2'd2, 16'hBEEF); rd(2'd2, v); check("R1 alarm readback", v, 16'hBEEF);
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2 R8 all ones", v, cw(7, 1, 1, 0, 1, 1));
    wr(2'd0, 16'h0000);

    // R3 random prescaler runs
    for (int i = 0; i < 16; i++) begin
      int n = int'($urandom % 8);
      int w = int'($urandom % 400);
      logic [15:0] s = 16'($urandom);
      wr(2'd1, s);
      wr(2'd0, cw(n, 0, 0, 0, 0, 1));
      idle(w);
      wr(2'd0, 16'h0000);
      rd(2'd1, v); check("R3 prescaled count", v, exp_count(s, n, w + 1));
    end

    // R4 wrap, R5 hold while stopped
    wr(2'd1, 16'hFFFE);
    wr(2'd0, cw(0, 0, 0, 0, 0, 1));
    idle(4);
    wr(2'd0, 16'h0000);
    rd(2'd1, v); check("R4 wrap", v, 16'h0003);
    idle(10);
    rd(2'd1, v); check("R5 stopped hold", v, 16'h0003);
    wr(2'd1, 16'h0010);
    wr(2'd0, cw(2, 0, 0, 0, 0, 1));
    idle(6);
    wr(2'd0, cw(2, 0, 0, 0, 0, 0));
    rd(2'd1, v); check("R3 div4 short run", v, 16'h0011);

    // R6 match, R10 irq, R8 clear and parked count
    wr(2'd2, 16'h0100);
    wr(2'd1, 16'h00FD);
    wr(2'd0, cw(0, 0, 0, 0, 1, 1));
    idle(5);
    rd(2'd0, v); check("R6 flag set on match", v, cw(0, 0, 0, 1, 1, 1));
    wr(2'd0, cw(0, 0, 0, 1, 1, 0));
    check("R10 irq off without enable", 16'(irq), 16'h0000);
    wr(2'd0, cw(0, 0, 1, 1, 1, 0));
    check("R10 irq on", 16'(irq), 16'h0001);
    wr(2'd0, cw(0, 0, 1, 0, 1, 0));
    rd(2'd0, v); check("R8 clear flag", v, cw(0, 0, 1, 0, 1, 0));
    check("R10 irq after clear", 16'(irq), 16'h0000);
    wr(2'd1, 16'h0100);
    idle(8);
    rd(2'd0, v); check("R8 parked no reset", v, cw(0, 0, 1, 0, 1, 0));

    // R7 alarm disabled
    wr(2'd1, 16'h00FE);
    wr(2'd0, cw(0, 0, 1, 0, 0, 1));
    idle(5);
    wr(2'd0, cw(0, 0, 1, 0, 0, 0));
    rd(2'd0, v); check("R7 no flag without alarm enable", v, cw(0, 0, 1, 0, 0, 0));
    check("R7 irq low", 16'(irq), 16'h0000);

    // R9 match beats clearing write
    wr(2'd1, 16'h00FD);
    wr(2'd0, cw(0, 0, 0, 0, 1, 1));
    idle(5);
    wr(2'd0, cw(0, 0, 0, 1, 1, 0));
    wr(2'd1, 16'h00FE);
    wr(2'd0, cw(0, 0, 0, 1, 1, 1));
    idle(1);
    wr(2'd0, cw(0, 0, 0, 0, 1, 1));
    wr(2'd0, cw(0, 0, 0, 1, 1, 0));
    rd(2'd0, v); check("R9 match wins over clear", v, cw(0, 0, 0, 1, 1, 0));
    wr(2'd0, cw(0, 0, 0, 0, 1, 0));
    rd(2'd0, v); check("R8 plain clear", v, cw(0, 0, 0, 0, 1, 0));

    // R12 unarmed sync ignored
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h1234);
    sync_in = 1'b1; idle(5); sync_in = 1'b0; idle(3);
    rd(2'd1, v); check("R12 unarmed sync", v, 16'h1234);

    // R11 armed sync, one shot
    wr(2'd0, cw(0, 1, 0, 0, 0, 0));
    rd(2'd0, v); check("R11 arm readback", v, cw(0, 1, 0, 0, 0, 0));
    sync_in = 1'b1; idle(4);
    rd(2'd1, v); check("R11 sync zeroes count", v, 16'h0000);
    rd(2'd0, v); check("R11 arm self clears", v, 16'h0000);
    sync_in = 1'b0; idle(3);
    wr(2'd1, 16'h0055);
    sync_in = 1'b1; idle(5); sync_in = 1'b0; idle(3);
    rd(2'd1, v); check("R11 one shot", v, 16'h0055);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule